// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Receiver with ID Wait

This block receives asynchronous serial frames on a single input line and sits in a shared-line system where several processors listen to one sender. Each frame carries a start bit (low), eight data bits with the least significant bit first, a ninth "address marker" bit and one stop bit (high). When the marker bit is 1, the frame is an ID frame that names a receiving station. When it is 0, the frame is ordinary data.

Software arms an ID wait. While the wait is armed, the hardware drops every data frame without a trace, so only the next ID frame reaches the receive register. Software then compares that ID with its own. On a mismatch it re-arms the wait and clears the full flag, and the data that follows for other stations is skipped. The block reports a full flag, an overrun flag and a framing flag. After either error it stops receiving until software clears both error flags. The live, synchronized line level can be read so that software can recognise a break. Baud generation is external: an oversampling tick is an input.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, full, overrun, framing_err, id_wait, rx_irq and err_irq are all 0.
- R2: A frame sends its data bits least significant bit first, then the marker bit, then the stop bit. When such a frame completes with a stop bit of 1 while id_wait is 0 and full is 0, rx_data takes its eight data bits, rx_mpb takes its marker bit and full becomes 1.
- R3: rx_irq equals full. A one-cycle pulse on clr_full returns full and rx_irq to 0.
- R4: A valid frame that completes while full is 1 sets overrun to 1 and leaves rx_data unchanged.
- R5: While overrun or framing_err is 1, completed frames change neither full nor rx_data. Reception resumes once both flags have been cleared with clr_overrun and clr_framing.
- R6: A frame whose stop bit is sampled as 0 sets framing_err and does not set full. err_irq equals overrun OR framing_err. rx_level follows the synchronized line level, so it reads 0 during a break.
- R7: A pulse on arm_id_wait sets id_wait to 1. While id_wait is 1, a frame with marker bit 0 changes none of full, overrun, framing_err, rx_data and id_wait, even if its stop bit is 0.
- R8: A valid frame with marker bit 1 that is accepted clears id_wait, sets full and sets rx_mpb to 1.
- R9: Once id_wait is 0, frames with marker bit 0 are accepted again, and rx_mpb reads 0 for them.
- R10: A start edge is confirmed only if the line is still low half a bit period later. A low glitch shorter than that produces no frame and does not shift the timing of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling tick, OVERSAMPLE ticks per bit |
| rxd | input | 1 | Serial input line, idle high |
| arm_id_wait | input | 1 | Pulse: set id_wait |
| clr_full | input | 1 | Pulse: clear full |
| clr_overrun | input | 1 | Pulse: clear overrun |
| clr_framing | input | 1 | Pulse: clear framing_err |
| rx_data | output | 8 | Receive data register |
| rx_mpb | output | 1 | Marker bit of the last accepted frame |
| id_wait | output | 1 | ID wait armed |
| full | output | 1 | Receive register holds unread data |
| overrun | output | 1 | Overrun flag |
| framing_err | output | 1 | Framing error flag |
| rx_level | output | 1 | Synchronized live line level |
| rx_irq | output | 1 | Receive interrupt request |
| err_irq | output | 1 | Error interrupt request |

## Verification
The bench builds the block with OVERSAMPLE set to 8 and the tick held high on every cycle. A bit then lasts eight clocks, and a whole frame of eleven bits takes under a hundred cycles, so every flag path, the glitch filter and the lockout sequence can be reached in a short run. The default two-stage synchronizer stays in place, so the latency of the line is the same as in real use. With an oversampling factor of 8, the half-bit confirmation point falls at tick 4, and a two-clock glitch sits clearly below that point.

// File: rtl/mpr_pkg.sv
// Shared types for the multiprocessor-mode receiver.
package mpr_pkg;
    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_START = 2'd1,
        FR_BITS  = 2'd2
    } fr_state_t;
endpackage

// File: rtl/mpr_sync.sv
// Line synchronizer: brings the asynchronous serial input into the clock
// domain through STAGES flip-flops. Assumes the idle line level is 1, so
// every stage resets to 1.
module mpr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw line level through the synchronizer chain.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/mpr_framer.sv
// Frame assembler. It looks for a falling edge on os_tick samples and
// confirms the start bit half a bit later. After that it samples each bit
// at its middle: the data bits, then the marker bit, then the stop bit.
// It pulses done for one cycle with the assembled fields.
// Assumes that os_tick arrives OVERSAMPLE times per bit period. While hold
// is high, no new frame is started.
module mpr_framer
    import mpr_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx,
    input  logic                 hold,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 mpb,
    output logic                 stop_ok
);
    localparam int NBITS = DATA_BITS + 2;
    localparam int CW    = $clog2(OVERSAMPLE);
    localparam int IW    = $clog2(NBITS);
    localparam int HALF  = OVERSAMPLE / 2;

    fr_state_t         state;
    logic [CW-1:0]     cnt;
    logic [IW-1:0]     idx;
    logic              prev;
    logic [NBITS-1:0]  sh;

    // Main sequencer: edge search, start confirmation, mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
            idx   <= '0;
            prev  <= 1'b1;
            sh    <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    FR_IDLE: begin
                        prev <= rx;
                        if (prev && !rx && !hold) begin
                            state <= FR_START;
                            cnt   <= '0;
                        end
                    end
                    FR_START: begin
                        if (cnt == CW'(HALF - 1)) begin
                            if (!rx) begin
                                state <= FR_BITS;
                                cnt   <= '0;
                                idx   <= '0;
                            end else begin
                                state <= FR_IDLE;
                                prev  <= rx;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    FR_BITS: begin
                        if (cnt == CW'(OVERSAMPLE - 1)) begin
                            cnt <= '0;
                            sh  <= {rx, sh[NBITS-1:1]};
                            if (idx == IW'(NBITS - 1)) begin
                                state <= FR_IDLE;
                                done  <= 1'b1;
                                prev  <= rx;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= FR_IDLE;
                endcase
            end
        end
    end

    assign data    = sh[DATA_BITS-1:0];
    assign mpb     = sh[DATA_BITS];
    assign stop_ok = sh[NBITS-1];

    // R2: a completion pulse lasts exactly one cycle
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: a frame cannot be in bit sampling without a confirmed start
    p_bits_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE) |=> (state != FR_BITS));
endmodule

// File: rtl/mpr_ctrl.sv
// Receive register and flag keeper. It applies the ID-wait filter, the
// overrun and framing checks and the error lockout to each completed frame.
// Software clear and arm pulses are applied first. An event from a frame in
// the same cycle takes priority over them.
module mpr_ctrl #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] data_in,
    input  logic                 mpb_in,
    input  logic                 stop_ok,
    input  logic                 arm_id_wait,
    input  logic                 clr_full,
    input  logic                 clr_overrun,
    input  logic                 clr_framing,
    output logic [DATA_BITS-1:0] rdr,
    output logic                 rdr_mpb,
    output logic                 id_wait,
    output logic                 full,
    output logic                 overrun,
    output logic                 framing_err
);
    logic locked;
    logic skip;

    assign locked = overrun | framing_err;
    assign skip   = id_wait & ~mpb_in;

    // Update register and flags from software pulses and frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdr         <= '0;
            rdr_mpb     <= 1'b0;
            id_wait     <= 1'b0;
            full        <= 1'b0;
            overrun     <= 1'b0;
            framing_err <= 1'b0;
        end else begin
            if (arm_id_wait) id_wait     <= 1'b1;
            if (clr_full)    full        <= 1'b0;
            if (clr_overrun) overrun     <= 1'b0;
            if (clr_framing) framing_err <= 1'b0;
            if (done && !locked && !skip) begin
                if (!stop_ok) begin
                    framing_err <= 1'b1;
                end else if (full) begin
                    overrun <= 1'b1;
                end else begin
                    rdr     <= data_in;
                    rdr_mpb <= mpb_in;
                    full    <= 1'b1;
                    if (mpb_in) id_wait <= 1'b0;
                end
            end
        end
    end

    // R4: overrun never coincides with a register update
    p_ovr_keeps_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rdr));

    // R5: while locked and uncleared, full cannot rise
    p_lockout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr_overrun && !clr_framing) |=> !$rose(full));

    // R7: a skipped data frame leaves every flag and the register alone
    p_filter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && id_wait && !mpb_in && !clr_full && !clr_overrun && !clr_framing)
        |=> ($stable(full) && $stable(overrun) && $stable(framing_err)
             && $stable(rdr) && id_wait));

    // R8: an accepted ID frame ends the wait and fills the register
    p_id_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !locked && mpb_in && stop_ok && !full && !arm_id_wait)
        |=> (!id_wait && full && rdr_mpb));

    // R6: a bad stop bit on an unfiltered, unlocked frame flags framing
    p_framing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !locked && !skip && !stop_ok) |=> framing_err);
endmodule

// File: rtl/mp_uart_rx.sv
// Top of the multiprocessor-mode serial receiver. It connects the line
// synchronizer, the frame assembler and the flag keeper, and derives the
// two interrupt requests. Assumes os_tick is produced by an external
// baud generator at OVERSAMPLE ticks per bit.
module mp_uart_rx #(
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       os_tick,
    input  logic       rxd,
    input  logic       arm_id_wait,
    input  logic       clr_full,
    input  logic       clr_overrun,
    input  logic       clr_framing,
    output logic [7:0] rx_data,
    output logic       rx_mpb,
    output logic       id_wait,
    output logic       full,
    output logic       overrun,
    output logic       framing_err,
    output logic       rx_level,
    output logic       rx_irq,
    output logic       err_irq
);
    localparam int DATA_BITS = 8;

    logic                 rx_s;
    logic                 fr_done;
    logic [DATA_BITS-1:0] fr_data;
    logic                 fr_mpb;
    logic                 fr_stop_ok;

    mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rx_s)
    );

    mpr_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (os_tick),
        .rx      (rx_s),
        .hold    (overrun | framing_err),
        .done    (fr_done),
        .data    (fr_data),
        .mpb     (fr_mpb),
        .stop_ok (fr_stop_ok)
    );

    mpr_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (fr_done),
        .data_in     (fr_data),
        .mpb_in      (fr_mpb),
        .stop_ok     (fr_stop_ok),
        .arm_id_wait (arm_id_wait),
        .clr_full    (clr_full),
        .clr_overrun (clr_overrun),
        .clr_framing (clr_framing),
        .rdr         (rx_data),
        .rdr_mpb     (rx_mpb),
        .id_wait     (id_wait),
        .full        (full),
        .overrun     (overrun),
        .framing_err (framing_err)
    );

    assign rx_level = rx_s;
    assign rx_irq   = full;
    assign err_irq  = overrun | framing_err;

    // R3: the receive request tracks the full flag
    p_rxi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> rx_irq);

    // R6: an error request is raised the cycle framing is flagged
    p_eri_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(framing_err) |-> err_irq);
endmodule

// File: tb/mp_uart_rx_bench.sv
module mp_uart_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 8;
    localparam int BIT        = OVS;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       arm_id_wait = 1'b0;
    logic       clr_full = 1'b0;
    logic       clr_overrun = 1'b0;
    logic       clr_framing = 1'b0;
    logic [7:0] rx_data;
    logic       rx_mpb, id_wait, full, overrun, framing_err;
    logic       rx_level, rx_irq, err_irq;

    int checks = 0;
    int errors = 0;
    logic [8:0] exp_q[$];
    logic       full_q = 1'b0;
    bit         done_run = 1'b0;

    mp_uart_rx #(.OVERSAMPLE(OVS), .SYNC_STAGES(2)) u_mp_uart_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .arm_id_wait(arm_id_wait), .clr_full(clr_full),
        .clr_overrun(clr_overrun), .clr_framing(clr_framing),
        .rx_data(rx_data), .rx_mpb(rx_mpb), .id_wait(id_wait), .full(full),
        .overrun(overrun), .framing_err(framing_err), .rx_level(rx_level),
        .rx_irq(rx_irq), .err_irq(err_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: sends one frame and, if acceptance is expected, queues it.
    task automatic send(input logic [7:0] d, input logic m, input logic stp,
                        input bit expect_it);
        if (expect_it) exp_q.push_back({m, d});
        rxd = 1'b0; idle(BIT);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; idle(BIT);
        end
        rxd = m;   idle(BIT);
        rxd = stp; idle(BIT);
        rxd = 1'b1; idle(2 * BIT);
    endtask

    task automatic pulse_clr_full;    clr_full = 1'b1;    idle(1); clr_full = 1'b0;    idle(1); endtask
    task automatic pulse_clr_overrun; clr_overrun = 1'b1; idle(1); clr_overrun = 1'b0; idle(1); endtask
    task automatic pulse_clr_framing; clr_framing = 1'b1; idle(1); clr_framing = 1'b0; idle(1); endtask
    task automatic pulse_arm;         arm_id_wait = 1'b1; idle(1); arm_id_wait = 1'b0; idle(1); endtask

    // Monitor: on each rise of full, pop and compare the expected frame (R2).
    always @(negedge clk) begin
        if (rst_n) begin
            if (full && !full_q) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected frame", {rx_mpb, rx_data}, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    check({rx_mpb, rx_data} == e, "R2", "frame contents",
                          {rx_mpb, rx_data}, e);
                end
            end
            full_q <= full;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check({full, overrun, framing_err, id_wait, rx_irq, err_irq} == 6'b0,
              "R1", "flags after reset",
              {full, overrun, framing_err, id_wait, rx_irq, err_irq}, 0);

        // R2 plain data frame
        send(8'hA5, 1'b0, 1'b1, 1'b1);
        check(full == 1'b1, "R2", "full after frame", full, 1);
        check(rx_mpb == 1'b0, "R9", "marker reads 0", rx_mpb, 0);
        // R3 request follows full
        check(rx_irq == 1'b1, "R3", "rx_irq set", rx_irq, 1);
        pulse_clr_full;
        check({full, rx_irq} == 2'b00, "R3", "cleared full/rx_irq", {full, rx_irq}, 0);

        // R4 overrun keeps data
        send(8'h3C, 1'b0, 1'b1, 1'b1);
        send(8'h81, 1'b0, 1'b1, 1'b0);
        check(overrun == 1'b1, "R4", "overrun set", overrun, 1);
        check(rx_data == 8'h3C, "R4", "data kept", rx_data, 8'h3C);
        check(err_irq == 1'b1, "R6", "err_irq on overrun", err_irq, 1);

        // R5 lockout until cleared
        pulse_clr_full;
        send(8'h55, 1'b0, 1'b1, 1'b0);
        check(full == 1'b0, "R5", "no reception while locked", full, 0);
        check(rx_data == 8'h3C, "R5", "data untouched while locked", rx_data, 8'h3C);
        pulse_clr_overrun;
        send(8'h66, 1'b0, 1'b1, 1'b1);
        check(full == 1'b1, "R5", "reception resumes", full, 1);
        pulse_clr_full;

        // R6 framing error and break level
        exp_q.delete();
        rxd = 1'b0; idle(BIT);
        for (int i = 0; i < 8; i++) begin rxd = 1'b0; idle(BIT); end
        rxd = 1'b0; idle(BIT);
        rxd = 1'b0; idle(2 * BIT);
        check(framing_err == 1'b1, "R6", "framing flag", framing_err, 1);
        check(full == 1'b0, "R6", "full not set on framing", full, 0);
        check(rx_level == 1'b0, "R6", "break level visible", rx_level, 0);
        check(err_irq == 1'b1, "R6", "err_irq on framing", err_irq, 1);
        rxd = 1'b1; idle(2 * BIT);
        check(rx_level == 1'b1, "R6", "line level released", rx_level, 1);
        pulse_clr_framing;
        check(err_irq == 1'b0, "R6", "err_irq cleared", err_irq, 0);

        // R7 ID wait skips data frames
        pulse_arm;
        check(id_wait == 1'b1, "R7", "wait armed", id_wait, 1);
        send(8'h77, 1'b0, 1'b1, 1'b0);
        check({full, id_wait} == 2'b01, "R7", "data frame skipped", {full, id_wait}, 1);
        send(8'h70, 1'b0, 1'b0, 1'b0);
        check(framing_err == 1'b0, "R7", "skipped frame sets no framing", framing_err, 0);

        // R8 ID frame accepted
        send(8'h42, 1'b1, 1'b1, 1'b1);
        check({full, id_wait, rx_mpb} == 3'b101, "R8", "ID accepted",
              {full, id_wait, rx_mpb}, 3'b101);

        // R9 data after the wait ends
        pulse_clr_full;
        send(8'h99, 1'b0, 1'b1, 1'b1);
        check({full, rx_mpb} == 2'b10, "R9", "data accepted after ID", {full, rx_mpb}, 2'b10);
        // R7 re-arm after mismatch
        pulse_arm;
        pulse_clr_full;
        send(8'h98, 1'b0, 1'b1, 1'b0);
        check(full == 1'b0, "R7", "re-armed wait skips data", full, 0);

        // R10 short glitch ignored, next frame aligned
        rxd = 1'b0; idle(2);
        rxd = 1'b1; idle(3 * BIT);
        check(full == 1'b0, "R10", "glitch yields no frame", full, 0);
        send(8'h5A, 1'b1, 1'b1, 1'b1);
        check(full == 1'b1, "R10", "frame after glitch", full, 1);
        check(rx_data == 8'h5A, "R10", "frame after glitch data", rx_data, 8'h5A);

        idle(4);
        check(exp_q.size() == 0, "R2", "all expected frames seen", exp_q.size(), 0);
        done_run = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule